// File: doc/BRIEF.md
# Bypassing Carry-Save Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. It is purely combinational. The product is formed by a visible array of full-adder cells rather than a behavioural `*`. Row 0 is the plain partial products of the multiplier operand's bit 0. It is followed by `WIDTH-1` carry-save rows of `WIDTH-1` cells each. Every cell sends its sum straight down at the same weight and its carry down-left, one weight higher. A closing ripple-carry row merges the leftover sum and carry vectors into the product.

The compile-time parameter `MODE` selects how zero operand bits switch off parts of the array.
- In row-skip mode (`BYP_ROW`), carry-save row k works only when bit k of the multiplier operand `b_i` is 1. A skipped row hands its incoming sum vector and its pending carries down unchanged, and its own adders give no carry.
- In column-skip mode (`BYP_COL`), each cell of diagonal i works only when bit i of the multiplicand `a_i` is 1. A switched-off cell passes the sum from above. When it has a carry-in, it merges that carry in a small half adder.

In both modes the full adder of a switched-off cell has all three inputs AND-gated to zero, so it does not toggle. A debug output shows which rows or diagonals are working.

Top module: `bypass_array_mul`

## Requirements
- R1: In row-skip mode `prod_o` equals the unsigned product `a_i * b_i` over all `2*WIDTH` bits.
- R2: In column-skip mode `prod_o` equals the unsigned product `a_i * b_i` over all `2*WIDTH` bits.
- R3: Operands that are all ones give `(2^WIDTH-1)^2`, and operands with a single bit set give the matching power of two, in both modes.
- R4: In row-skip mode, bit k-1 of `act_mask_o` is 1 exactly when bit k of `b_i` is 1, for k from 1 to WIDTH-1. For example, with WIDTH 8, `b_i = 8'h09` gives the mask `7'b0000100`.
- R5: In column-skip mode, bit i of `act_mask_o` is 1 exactly when bit i of `a_i` is 1, for i from 0 to WIDTH-2.
- R6: In row-skip mode, a row whose multiplier bit is 0 outputs exactly the sum and carry vectors it received.
- R7: In column-skip mode, a switched-off cell with no carry-in outputs the sum from above as its sum.
- R8: The closing ripple row carries into the top product bit, so `prod_o[2*WIDTH-1]` is set when the product reaches `2^(2*WIDTH-1)`, for example 8'hFF times 8'hFF gives 16'hFE01.
- R9: When either operand is zero, `prod_o` is zero in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Multiplicand, unsigned |
| b_i | input | WIDTH | Multiplier operand, unsigned |
| prod_o | output | 2*WIDTH | Full unsigned product |
| act_mask_o | output | WIDTH-1 | Working rows (row-skip mode) or working diagonals (column-skip mode), one bit each |

## Verification
The hardest case to reach is a skipped row or a switched-off cell that still has pending carries. Row-skip mode must then carry them down unchanged, and column-skip mode must merge them without the full adder. A wrong product appears only when a dense multiplicand meets an active row followed by zero rows, or when a zero multiplicand bit lies among active neighbours. The stimulus table therefore holds pairs such as 8'hFF times 8'h81, 8'hFB times 8'hFF and 8'hB6 times 8'h6D. Both mode variants are driven with the same operands, and a long run of random operands follows.

// File: rtl/mulbp_pkg.sv
package mulbp_pkg;
    typedef enum logic [0:0] {
        BYP_ROW = 1'b0,
        BYP_COL = 1'b1
    } bypass_mode_e;
endpackage

// File: rtl/mulbp_cell.sv
module mulbp_cell
    import mulbp_pkg::*;
#(
    parameter bypass_mode_e MODE = BYP_ROW
) (
    input  logic en_i,
    input  logic pp_i,
    input  logic s_i,
    input  logic c_i,
    output logic sum_o,
    output logic cy_o,
    output logic keep_o
);
    logic pp_g, s_g, c_g;
    logic fa_s, fa_c;

    // operand isolation: an idle full adder sees constant zeros
    always_comb begin
        pp_g = pp_i & en_i;
        s_g  = s_i  & en_i;
        c_g  = c_i  & en_i;
        fa_s = pp_g ^ s_g ^ c_g;
        fa_c = (pp_g & s_g) | (pp_g & c_g) | (s_g & c_g);
    end

    generate
        if (MODE == BYP_ROW) begin : g_row
            always_comb begin
                sum_o  = en_i ? fa_s : s_i;
                cy_o   = en_i ? fa_c : 1'b0;
                keep_o = en_i ? 1'b0 : c_i;
            end
        end else begin : g_col
            always_comb begin
                sum_o  = en_i ? fa_s : (s_i ^ c_i);
                cy_o   = en_i ? fa_c : (s_i & c_i);
                keep_o = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/mulbp_row.sv
module mulbp_row
    import mulbp_pkg::*;
#(
    parameter int           WIDTH = 8,
    parameter int           ROW   = 1,
    parameter bypass_mode_e MODE  = BYP_ROW
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic               b_bit_i,
    input  logic [2*WIDTH-1:0] s_i,
    input  logic [2*WIDTH-1:0] c_i,
    output logic [2*WIDTH-1:0] s_o,
    output logic [2*WIDTH-1:0] c_o
);
    localparam int CELLS = WIDTH - 1;
    localparam int TOPW  = ROW + WIDTH - 1;

    logic [CELLS-1:0] en, sum, cy, keep;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        if (MODE == BYP_ROW) begin : g_en_row
            assign en[i] = b_bit_i;
        end else begin : g_en_col
            assign en[i] = a_i[i];
        end
        mulbp_cell #(.MODE(MODE)) cell_i (
            .en_i   (en[i]),
            .pp_i   (a_i[i] & b_bit_i),
            .s_i    (s_i[i+ROW]),
            .c_i    (c_i[i+ROW]),
            .sum_o  (sum[i]),
            .cy_o   (cy[i]),
            .keep_o (keep[i])
        );
    end

    always_comb begin
        s_o = s_i;
        c_o = c_i;
        for (int i = 0; i < CELLS; i++) begin
            s_o[i+ROW] = sum[i];
            c_o[i+ROW] = keep[i];
        end
        for (int i = 0; i < CELLS; i++) begin
            c_o[i+ROW+1] = c_o[i+ROW+1] | cy[i];
        end
        s_o[TOPW] = s_i[TOPW] | (a_i[WIDTH-1] & b_bit_i);
    end

    // R6: a skipped row leaves both vectors untouched
    always_comb begin
        if (MODE == BYP_ROW && !b_bit_i) begin
            p_row_pass_r6: assert (s_o == s_i && c_o == c_i)
                else $error("skipped row %0d altered its vectors", ROW);
        end
    end

    // R7: idle diagonal cell with no pending carry forwards the sum from above
    always_comb begin
        for (int i = 0; i < CELLS; i++) begin
            if (MODE == BYP_COL && !a_i[i] && !c_i[i+ROW]) begin
                p_col_pass_r7: assert (sum[i] == s_i[i+ROW] && !cy[i])
                    else $error("idle cell %0d of row %0d did not forward", i, ROW);
            end
        end
    end
endmodule

// File: rtl/mulbp_ripple.sv
module mulbp_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]   = x_i[i] ^ y_i[i] ^ carry[i];
        assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
    end

    // R8: the chain resolves every carry and never spills past the top bit
    always_comb begin
        p_ripple_sum_r8: assert ({carry[W], sum_o} == ({1'b0, x_i} + {1'b0, y_i}))
            else $error("ripple row sum mismatch");
    end
endmodule

// File: rtl/bypass_array_mul.sv
module bypass_array_mul
    import mulbp_pkg::*;
#(
    parameter int           WIDTH = 8,
    parameter bypass_mode_e MODE  = BYP_ROW
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [2*WIDTH-1:0] prod_o,
    output logic [WIDTH-2:0]   act_mask_o
);
    localparam int PW    = 2 * WIDTH;
    localparam int NROWS = WIDTH - 1;

    logic [PW-1:0] sv [NROWS+1];
    logic [PW-1:0] cv [NROWS+1];

    assign sv[0] = {{WIDTH{1'b0}}, a_i & {WIDTH{b_i[0]}}};
    assign cv[0] = '0;

    for (genvar k = 1; k <= NROWS; k++) begin : g_row
        mulbp_row #(.WIDTH(WIDTH), .ROW(k), .MODE(MODE)) row_i (
            .a_i     (a_i),
            .b_bit_i (b_i[k]),
            .s_i     (sv[k-1]),
            .c_i     (cv[k-1]),
            .s_o     (sv[k]),
            .c_o     (cv[k])
        );
    end

    mulbp_ripple #(.W(PW)) final_i (
        .x_i   (sv[NROWS]),
        .y_i   (cv[NROWS]),
        .sum_o (prod_o)
    );

    generate
        if (MODE == BYP_ROW) begin : g_mask_row
            assign act_mask_o = b_i[WIDTH-1:1];
        end else begin : g_mask_col
            assign act_mask_o = a_i[WIDTH-2:0];
        end
    endgenerate

    logic [PW-1:0] ref_prod;
    assign ref_prod = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};

    always_comb begin
        if (MODE == BYP_ROW) begin
            p_product_r1: assert (prod_o == ref_prod)
                else $error("row-skip product mismatch");
        end else begin
            p_product_r2: assert (prod_o == ref_prod)
                else $error("column-skip product mismatch");
        end
    end

    always_comb begin
        if (a_i == '0 || b_i == '0) begin
            p_zero_operand_r9: assert (prod_o == '0)
                else $error("zero operand gave nonzero product");
        end
    end

    always_comb begin
        if (&a_i && &b_i) begin
            p_all_ones_r3: assert (prod_o[PW-1] && prod_o[WIDTH-1:1] == '0 && prod_o[0])
                else $error("all-ones product has wrong shape");
        end
    end
endmodule

// File: tb/bypass_array_mul_tb_top.sv
module bypass_array_mul_tb_top;
    import mulbp_pkg::*;

    localparam int W  = 8;
    localparam int PW = 2 * W;
    localparam int NV = 12;

    // {a, b, expected product}
    localparam logic [31:0] VEC [NV] = '{
        {8'h0F, 8'h09, 16'h0087},
        {8'hFF, 8'hFF, 16'hFE01},
        {8'h80, 8'h80, 16'h4000},
        {8'hAA, 8'h55, 16'h3872},
        {8'h01, 8'hFF, 16'h00FF},
        {8'h00, 8'hC3, 16'h0000},
        {8'h12, 8'h34, 16'h03A8},
        {8'h7F, 8'h81, 16'h3FFF},
        {8'hF0, 8'h0F, 16'h0E10},
        {8'hB6, 8'h6D, 16'h4D7E},
        {8'hFF, 8'h81, 16'h807F},
        {8'hFB, 8'hFF, 16'hFA05}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0]  a_r, b_r;
    logic [PW-1:0] prod_row, prod_col;
    logic [W-2:0]  mask_row, mask_col;
    int n_chk  = 0;
    int n_fail = 0;

    bypass_array_mul #(.WIDTH(W), .MODE(BYP_ROW)) dut_i (
        .a_i (a_r), .b_i (b_r), .prod_o (prod_row), .act_mask_o (mask_row)
    );
    bypass_array_mul #(.WIDTH(W), .MODE(BYP_COL)) dut_col_i (
        .a_i (a_r), .b_i (b_r), .prod_o (prod_col), .act_mask_o (mask_col)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a_r, b_r, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        a_r = a;
        b_r = b;
        #1;
    endtask

    task automatic chk_both(input logic [PW-1:0] exp);
        chk("R1 row-skip product", {16'h0, prod_row}, {16'h0, exp});
        chk("R2 column-skip product", {16'h0, prod_col}, {16'h0, exp});
        chk("R4 row mask", {25'h0, mask_row}, {25'h0, b_r[W-1:1]});
        chk("R5 column mask", {25'h0, mask_col}, {25'h0, a_r[W-2:0]});
    endtask

    initial begin
        a_r = '0;
        b_r = '0;
        // idle state: zero operands
        apply(8'h00, 8'h00);
        chk("R9 zero row", {16'h0, prod_row}, 32'h0);
        chk("R9 zero col", {16'h0, prod_col}, 32'h0);
        chk("R4 zero mask", {25'h0, mask_row}, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][31:24], VEC[v][23:16]);
            chk_both(VEC[v][15:0]);
        end

        // R4 / R6: 8'h0F x 8'h09 skips rows 1 and 2, only row 3 works
        apply(8'h0F, 8'h09);
        chk("R4 mask for b=09", {25'h0, mask_row}, 32'h04);
        chk("R6 product with skipped rows", {16'h0, prod_row}, 32'h0087);

        // R3 / R8: all ones reaches the top bit
        apply(8'hFF, 8'hFF);
        chk("R8 top bit row", {31'h0, prod_row[PW-1]}, 32'h1);
        chk("R3 all ones col", {16'h0, prod_col}, 32'hFE01);

        // R3: single set bits give powers of two
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                apply(W'(1) << i, W'(1) << j);
                chk("R3 single-bit row", {16'h0, prod_row}, 32'h1 << (i + j));
                chk("R3 single-bit col", {16'h0, prod_col}, 32'h1 << (i + j));
            end
        end

        // R9: one zero operand with dense other
        apply(8'hFF, 8'h00);
        chk("R9 b zero row", {16'h0, prod_row}, 32'h0);
        chk("R9 b zero col", {16'h0, prod_col}, 32'h0);
        apply(8'h00, 8'hFF);
        chk("R9 a zero row", {16'h0, prod_row}, 32'h0);
        chk("R9 a zero col", {16'h0, prod_col}, 32'h0);

        // R7: sparse multiplicands, idle diagonals between active ones
        apply(8'h81, 8'hFF);
        chk("R7 sparse a col", {16'h0, prod_col}, 32'h807F);
        apply(8'h41, 8'hE7);
        chk("R7 sparse a col 2", {16'h0, prod_col}, 32'h3AA7);

        // random operands
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            apply(ra, rb);
            chk_both({{W{1'b0}}, ra} * {{W{1'b0}}, rb});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule